// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus transfer at a time over a shared 16-bit address/data lane plus four upper lines that carry the high address bits and then status. A client pulses a request with the direction, the memory or I/O select, a 20-bit address, write data and four status bits. The sequencer then steps through four bus states, T1 to T4, and adds wait states while the target holds ready low.

In T1 the address is presented and the latch strobe is high. From T2 the shared lane either carries the write data or is released for the target to drive. The read and write strobes and the transceiver enable are active from T2 until the last wait state. Read data is captured on the clock edge that enters T4. In T4 all strobes return high and a one-cycle done pulse tells the client the transfer is complete.

The shared lane is brought out as separate `ad_o`, `ad_oe_o` and `ad_i` so that the pad ring can build the tristate.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, and while idle, `ale_o`=0, `rd_no`=`wr_no`=`den_no`=1, `done_o`=0, `ad_oe_o`=0, `a_hi_o`=0 and `rdata_o`=0.
- R2: A request sampled high while idle starts T1 on the next cycle. `ale_o` is high for exactly that one cycle. During it `ad_oe_o`=1, `ad_o`=address[15:0] and `a_hi_o`=address[19:16].
- R3: `m_io_o` (1 = memory, 0 = I/O) and `dt_r_o` (0 = read, 1 = write) take the request's values in T1. They hold them through T4, even if the inputs change.
- R4: In a read, `rd_no` and `den_no` are low in T2, T3 and every wait state. `wr_no` stays high all the cycle, and `ad_oe_o`=0 from T2 through T4.
- R5: In a write, `wr_no` and `den_no` are low in T2, T3 and every wait state, and `rd_no` stays high. `ad_oe_o`=1 with `ad_o` equal to the latched write data from T2 through T4.
- R6: From T2 through T4, `a_hi_o` carries the latched status bits in place of the upper address bits.
- R7: `ready_i` is sampled at the end of T3 and at the end of each wait state. When it is low, one more wait state follows with all strobes unchanged.
- R8: In a read, `rdata_o` takes `ad_i` at the edge that enters T4 and keeps it until the next read completes.
- R9: In T4, `rd_no`, `wr_no` and `den_no` are high and `done_o` is high for one cycle. The state after T4 is idle, so a transfer with N wait states spans 4+N cycles.
- R10: A request raised while a transfer is in progress is ignored and starts no new T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start strobe, taken only while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| mem_i | input | 1 | 1 = memory, 0 = I/O |
| addr_i | input | 20 | Transfer address |
| wdata_i | input | 16 | Write data |
| stat_i | input | 4 | Status bits shown on the upper lines after T1 |
| ready_i | input | 1 | Target ready; low inserts wait states |
| ad_i | input | 16 | Shared lane input from the pad |
| ad_o | output | 16 | Shared lane output value |
| ad_oe_o | output | 1 | Shared lane output enable |
| a_hi_o | output | 4 | Upper address in T1, status afterwards |
| ale_o | output | 1 | Address latch strobe, high in T1 |
| m_io_o | output | 1 | Memory (1) or I/O (0) |
| dt_r_o | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| den_no | output | 1 | Transceiver enable, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| rdata_o | output | 16 | Captured read data |
| done_o | output | 1 | One-cycle completion pulse in T4 |

## Verification
The hardest case to reach from the ports is a long wait-state run in which every address, data and status input changes while the strobes must stay unchanged. The bench must also show that the read value is taken exactly at the edge that leaves the last wait state. To reach it, the stimulus draws a random wait count for each transfer, rewrites all request inputs with random values right after T1, and pulses the request once during the transfer. It drives the expected read word on `ad_i` only up to the capture edge and replaces it with a different value in T4.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    ready_i,
  output bus_st_e state_o,
  output logic    accept_o,
  output logic    capture_o
);
  bus_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_TW:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_o   = state_q;
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_T3 || state_q == ST_TW) && ready_i;

  // R7
  wait_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TW) |-> !$past(ready_i));
  // R9
  t4_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_T4) |=> (state_q == ST_IDLE));
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_T1));
endmodule

// File: rtl/bus_seq_lanes.sv
module bus_seq_lanes
  import bus_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_st_e       state_i,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic          wr_i,
  input  logic          mem_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [HW-1:0] stat_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [HW-1:0] a_hi_o,
  output logic          m_io_o,
  output logic          dt_r_o,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [HW-1:0] stat_q;
  logic          wr_q, mem_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      stat_q  <= '0;
      wr_q    <= 1'b0;
      mem_q   <= 1'b0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      stat_q  <= stat_i;
      wr_q    <= wr_i;
      mem_q   <= mem_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                rdata_q <= '0;
    else if (capture_i && !wr_q) rdata_q <= ad_i;

  logic in_t1, data_phase;
  assign in_t1      = (state_i == ST_T1);
  assign data_phase = (state_i == ST_T2) || (state_i == ST_T3) ||
                      (state_i == ST_TW) || (state_i == ST_T4);

  assign ad_o    = in_t1 ? addr_q[DW-1:0] : wdata_q;
  assign ad_oe_o = in_t1 || (data_phase && wr_q);
  assign a_hi_o  = in_t1 ? addr_q[AW-1:DW] : (data_phase ? stat_q : '0);
  assign m_io_o  = mem_q;
  assign dt_r_o  = wr_q;
  assign rdata_o = rdata_q;

  // R3
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_phase |-> ($stable(m_io_o) && $stable(dt_r_o)));
  // R5
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && state_i != ST_T1 && state_i != ST_T2) |-> $stable(ad_o));
  // R8
  rdata_only_on_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o != $past(rdata_o)) |-> $past(capture_i));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic          mem_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [HW-1:0] stat_i,
  input  logic          ready_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [HW-1:0] a_hi_o,
  output logic          ale_o,
  output logic          m_io_o,
  output logic          dt_r_o,
  output logic          den_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  bus_st_e state;
  logic    accept, capture, strobe_win;

  bus_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ready_i   (ready_i),
    .state_o   (state),
    .accept_o  (accept),
    .capture_o (capture)
  );

  bus_seq_lanes #(.AW(AW), .DW(DW)) u_lanes (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .accept_i  (accept),
    .capture_i (capture),
    .wr_i      (wr_i),
    .mem_i     (mem_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .stat_i    (stat_i),
    .ad_i      (ad_i),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .a_hi_o    (a_hi_o),
    .m_io_o    (m_io_o),
    .dt_r_o    (dt_r_o),
    .rdata_o   (rdata_o)
  );

  // strobes active from T2 up to the last wait state
  assign strobe_win = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
  assign ale_o  = (state == ST_T1);
  assign den_no = !strobe_win;
  assign rd_no  = !(strobe_win && !dt_r_o);
  assign wr_no  = !(strobe_win && dt_r_o);
  assign done_o = (state == ST_T4);

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no || wr_no));
  // R2
  ale_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !ale_o));
  // R7
  strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(done_o) && !den_no && $past(!den_no) && !$past(ready_i))
      |-> ($stable(rd_no) && $stable(wr_no)));
endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, mem = 1'b0, ready = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0, ad_in = '0;
  logic [3:0]  stat = '0;
  logic [15:0] ad_out, rdata;
  logic        ad_oe, ale, m_io, dt_r, den_n, rd_n, wr_n, done;
  logic [3:0]  a_hi;
  int errors = 0, checks = 0;
  logic [15:0] last_rd = '0;

  always #2.5 clk = ~clk;

  bus_cycle_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .mem_i(mem),
    .addr_i(addr), .wdata_i(wdata), .stat_i(stat), .ready_i(ready),
    .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe), .a_hi_o(a_hi),
    .ale_o(ale), .m_io_o(m_io), .dt_r_o(dt_r), .den_no(den_n),
    .rd_no(rd_n), .wr_no(wr_n), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " ale"}, ale, 0);
    chk({tag, " rd_n"}, rd_n, 1);
    chk({tag, " wr_n"}, wr_n, 1);
    chk({tag, " den_n"}, den_n, 1);
    chk({tag, " done"}, done, 0);
    chk({tag, " ad_oe"}, ad_oe, 0);
    chk({tag, " a_hi"}, a_hi, 0);
  endtask

  // expected strobe set in T2/T3/wait states
  task automatic chk_active(input string st, input bit w, input logic [15:0] wd,
                            input logic [3:0] s, input bit m);
    chk({"R4/R5 den_n ", st}, den_n, 0);
    chk({"R4 rd_n ", st}, rd_n, w);
    chk({"R5 wr_n ", st}, wr_n, !w);
    chk({"R2 ale ", st}, ale, 0);
    chk({"R4/R5 ad_oe ", st}, ad_oe, w);
    if (w) chk({"R5 ad_o ", st}, ad_out, wd);
    chk({"R6 a_hi ", st}, a_hi, s);
    chk({"R3 m_io ", st}, m_io, m);
    chk({"R3 dt_r ", st}, dt_r, w);
    chk({"R9 done ", st}, done, 0);
  endtask

  task automatic xfer(input bit w, input bit m, input logic [19:0] a, input logic [15:0] wd,
                      input logic [3:0] s, input int nwait, input logic [15:0] rv,
                      input bit busy_req);
    @(negedge clk);
    req = 1; wr = w; mem = m; addr = a; wdata = wd; stat = s; ready = 1;
    @(negedge clk);  // T1
    req = 0;
    chk("R2 ale T1", ale, 1);
    chk("R2 ad_oe T1", ad_oe, 1);
    chk("R2 ad_o T1", ad_out, a[15:0]);
    chk("R2 a_hi T1", a_hi, a[19:16]);
    chk("R3 m_io T1", m_io, m);
    chk("R3 dt_r T1", dt_r, w);
    chk("R2 rd_n T1", rd_n, 1);
    chk("R2 wr_n T1", wr_n, 1);
    wr = $urandom; mem = $urandom; addr = $urandom; wdata = $urandom; stat = $urandom;
    @(negedge clk);  // T2
    chk_active("T2", w, wd, s, m);
    ad_in = rv;
    if (busy_req) req = 1;  // R10 stimulus
    @(negedge clk);  // T3
    req = 0;
    chk_active("T3", w, wd, s, m);
    ready = (nwait == 0);
    for (int i = 0; i < nwait; i++) begin
      @(negedge clk);
      chk_active("R7 wait", w, wd, s, m);
      ready = (i == nwait - 1);
    end
    @(negedge clk);  // T4
    ad_in = ~rv;
    ready = $urandom;
    chk("R9 done T4", done, 1);
    chk("R9 rd_n T4", rd_n, 1);
    chk("R9 wr_n T4", wr_n, 1);
    chk("R9 den_n T4", den_n, 1);
    chk("R4/R5 ad_oe T4", ad_oe, w);
    if (w) chk("R5 ad_o T4", ad_out, wd);
    chk("R6 a_hi T4", a_hi, s);
    chk("R3 m_io T4", m_io, m);
    chk("R3 dt_r T4", dt_r, w);
    if (!w) last_rd = rv;
    chk("R8 rdata T4", rdata, last_rd);
    @(negedge clk);  // idle again
    chk_idle(busy_req ? "R10 idle" : "R9 idle");
    chk("R8 rdata idle", rdata, last_rd);
    ready = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    chk("R1 rdata", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1 after release");
    xfer(0, 1, 20'h34EAA, 16'h0000, 4'h5, 0, 16'hBEEF, 0);
    xfer(1, 0, 20'h6933E, 16'hA55A, 4'hC, 3, 16'h1234, 0);
    xfer(0, 0, 20'hFFFFF, 16'hFFFF, 4'hF, 5, 16'h0F0F, 1);
    xfer(1, 1, 20'h00000, 16'h8001, 4'h0, 1, 16'h0000, 1);
    for (int n = 0; n < 40; n++)
      xfer($urandom, $urandom, $urandom, $urandom, $urandom,
           $urandom_range(0, 4), $urandom, $urandom);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule